// File: doc/BRIEF.md
# Command-Driven Identifier Allocator

This unit hands out and takes back process address-space identifiers on request from software. Software writes a command word into a memory-mapped command register. The unit marks its response register busy and carries out the operation against an internal bitmap pool of identifiers. When the operation is done, it publishes a status code and, for a successful allocation, the granted identifier. A read-only capability register tells software whether the allocation service is present.

The register bus is a single-cycle write strobe with a combinational read path. It supports 64-bit accesses and 32-bit accesses to either half of each register. An allocation scans the pool one entry per cycle, starting from identifier 1, and takes the lowest free entry. A release checks the named identifier and clears it. While a command is in progress, further command writes are dropped, so software must poll the busy flag before issuing the next command.

Top module: `vcmd_pasid_unit`

## Requirements
- R1: After reset, the capability register reads 1 in bit 0 when the service is enabled (0 when disabled), and the command and response registers read 0.
- R2: The capability register sits at offset 0xE00, the command register at 0xE10 and the response register at 0xE20. Each is 64 bits wide. A 32-bit read at offset +4 returns the upper half in data bits 31:0.
- R3: Writes to the capability and response registers have no effect.
- R4: Command opcode 1 (command bits 7:0) allocates the lowest free identifier in the range 1 to POOL_SIZE-1. The response then holds status 0 in bits 2:1 and the identifier in bits 27:8. Identifier 0 is never granted.
- R5: Response bit 0 (busy) is set from the cycle after acceptance until completion. An allocation that grants identifier k stays busy for k cycles. A release or an undefined command stays busy for 1 cycle. Busy clears in the same cycle that the status and result appear.
- R6: An accepted command overwrites the response register with exactly 1 (busy only), which discards any earlier status and result.
- R7: A command write that arrives while busy is set is dropped. The command register keeps its value and the running command finishes unaffected.
- R8: When the capability bit is clear, every command write is dropped. The command and response registers stay 0.
- R9: Any opcode other than 1 or 2 (including 0) completes with status 1 and no result.
- R10: An allocation with no free identifier completes with status 2 and result field 0.
- R11: Opcode 2 releases the identifier in command bits 27:8. A valid release completes with status 0, and a later allocation can grant that identifier again.
- R12: A release naming identifier 0, an identifier at or above POOL_SIZE, or an identifier that is not allocated completes with status 2 and leaves the pool unchanged.
- R13: A 32-bit write to either half of the command register merges with the stored other half and starts a command using the merged 64-bit value.
- R14: Reset empties the pool, so the first allocation after reset grants identifier 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wide | input | 1 | 1 = 64-bit access, 0 = 32-bit access |
| bus_addr | input | 12 | Byte offset of the access |
| bus_wdata | input | 64 | Write data (32-bit writes use bits 31:0) |
| bus_rdata | output | 64 | Read data for bus_addr, combinational |

## Verification
The assertions assume that an access is naturally aligned and that a 64-bit access never targets the upper-half offset. They also assume that software alone drives the command register, which means that only a bus write can change its value. The directed stimulus issues only aligned accesses. It performs each command write as a single-cycle strobe and keeps the bus idle while it polls the busy flag, except for the one deliberate write during a busy period. A release is checked against a bench-side record of the granted identifiers, so that invalid releases and re-allocation order are judged independently of the pool.

// File: rtl/vcmd_pasid_unit.sv
module vcmd_pasid_unit #(
  parameter int POOL_SIZE = 64,
  parameter bit CAP_PASID = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic        bus_wide,
  input  logic [11:0] bus_addr,
  input  logic [63:0] bus_wdata,
  output logic [63:0] bus_rdata
);

  // POOL_SIZE must lie in 2 .. 2**20
  localparam int              IDX_W    = $clog2(POOL_SIZE);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(POOL_SIZE - 1);
  localparam logic [20:0]     ID_LIMIT = 21'(POOL_SIZE);
  localparam logic [8:0]      QW_CAP   = 9'h1C0;
  localparam logic [8:0]      QW_CMD   = 9'h1C2;
  localparam logic [8:0]      QW_RSP   = 9'h1C4;
  localparam logic [7:0]      OP_ALLOC = 8'd1;
  localparam logic [7:0]      OP_FREE  = 8'd2;
  localparam logic [1:0]      SC_OK    = 2'd0;
  localparam logic [1:0]      SC_UNDEF = 2'd1;
  localparam logic [1:0]      SC_NOID  = 2'd2;

  typedef enum logic [1:0] {ST_IDLE, ST_SCAN, ST_EXEC} state_t;

  state_t           st_q;
  logic [63:0]      cmd_q, rsp_q;
  logic [IDX_W-1:0] scan_q;
  logic [POOL_SIZE-1:0] pool_q;

  function automatic logic [63:0] mk_rsp(input logic [1:0] sc, input logic [19:0] id);
    return {36'd0, id, 5'd0, sc, 1'b0};
  endfunction

  wire [63:0] cap_w = {63'd0, CAP_PASID};
  wire        aligned = (bus_addr[1:0] == 2'b00);

  logic [63:0] sel;
  always_comb begin
    case (bus_addr[11:3])
      QW_CAP:  sel = cap_w;
      QW_CMD:  sel = cmd_q;
      QW_RSP:  sel = rsp_q;
      default: sel = 64'd0;
    endcase
  end

  assign bus_rdata = !aligned      ? 64'd0 :
                     bus_wide      ? (bus_addr[2] ? 64'd0 : sel) :
                     bus_addr[2]   ? {32'd0, sel[63:32]} : {32'd0, sel[31:0]};

  wire cmd_hit = bus_wr && aligned && (bus_addr[11:3] == QW_CMD) && !(bus_wide && bus_addr[2]);
  wire [63:0] wval = bus_wide    ? bus_wdata :
                     bus_addr[2] ? {bus_wdata[31:0], cmd_q[31:0]} :
                                   {cmd_q[63:32], bus_wdata[31:0]};
  wire accept = cmd_hit && CAP_PASID && !rsp_q[0];

  wire [7:0]  op  = cmd_q[7:0];
  wire [19:0] arg = cmd_q[27:8];
  wire in_range = (arg != 20'd0) && ({1'b0, arg} < ID_LIMIT);
  wire free_ok  = in_range && pool_q[arg[IDX_W-1:0]];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cmd_q  <= 64'd0;
      rsp_q  <= 64'd0;
      scan_q <= IDX_W'(1);
      pool_q <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (accept) begin
          cmd_q  <= wval;
          rsp_q  <= 64'd1;
          scan_q <= IDX_W'(1);
          st_q   <= (wval[7:0] == OP_ALLOC) ? ST_SCAN : ST_EXEC;
        end
        ST_SCAN: begin
          if (!pool_q[scan_q]) begin
            pool_q[scan_q] <= 1'b1;
            rsp_q <= mk_rsp(SC_OK, 20'(scan_q));
            st_q  <= ST_IDLE;
          end else if (scan_q == LAST_IDX) begin
            rsp_q <= mk_rsp(SC_NOID, 20'd0);
            st_q  <= ST_IDLE;
          end else begin
            scan_q <= scan_q + IDX_W'(1);
          end
        end
        ST_EXEC: begin
          if (op == OP_FREE) begin
            if (free_ok) begin
              pool_q[arg[IDX_W-1:0]] <= 1'b0;
              rsp_q <= mk_rsp(SC_OK, 20'd0);
            end else begin
              rsp_q <= mk_rsp(SC_NOID, 20'd0);
            end
          end else begin
            rsp_q <= mk_rsp(SC_UNDEF, 20'd0);
          end
          st_q <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  AST_ACCEPT_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (rsp_q == 64'd1));  // R6
  AST_BUSY_DROPS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_hit && rsp_q[0]) |=> $stable(cmd_q));  // R7
  AST_GRANT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(rsp_q[0]) && op == OP_ALLOC && rsp_q[2:1] == SC_OK)
      |-> (rsp_q[27:8] != 20'd0 && {1'b0, rsp_q[27:8]} < ID_LIMIT));  // R4
  AST_ERR_NO_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(rsp_q[0]) && rsp_q[2:1] != SC_OK) |-> (rsp_q[63:8] == 56'd0));  // R10
  AST_RSP_SPARE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_q[7:3] == 5'd0 && rsp_q[63:28] == 36'd0 && rsp_q[2:1] != 2'd3));  // R5
  AST_NOCAP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !CAP_PASID |-> (rsp_q == 64'd0 && cmd_q == 64'd0));  // R8

endmodule

// File: tb/vcmd_pasid_unit_tb.sv
`timescale 1ns/1ps
module vcmd_pasid_unit_tb_top;
  localparam int PS = 16;

  logic clk = 1'b0, rst_n = 1'b0, bus_wr = 1'b0, nc_wr = 1'b0, bus_wide = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [63:0] bus_wdata = '0;
  wire  [63:0] rdata, nc_rdata;
  int errors = 0, checks = 0;
  logic [PS-1:0] used = '0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  vcmd_pasid_unit #(.POOL_SIZE(PS), .CAP_PASID(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_wide(bus_wide),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata));

  vcmd_pasid_unit #(.POOL_SIZE(PS), .CAP_PASID(1'b0)) dut_nocap (
    .clk(clk), .rst_n(rst_n), .bus_wr(nc_wr), .bus_wide(bus_wide),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(nc_rdata));

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input bit nc, input bit wide, input logic [11:0] a, input logic [63:0] d);
    @(negedge clk);
    bus_addr = a; bus_wide = wide; bus_wdata = d;
    bus_wr = !nc; nc_wr = nc;
    @(negedge clk);
    bus_wr = 1'b0; nc_wr = 1'b0;
  endtask

  task automatic rd(input bit nc, input bit wide, input logic [11:0] a, output logic [63:0] d);
    bus_addr = a; bus_wide = wide;
    #1;
    d = nc ? nc_rdata : rdata;
  endtask

  task automatic wait_done(output logic [63:0] r, output int busy);
    busy = 0;
    for (int i = 0; i < 1000; i++) begin
      rd(0, 1, 12'hE20, r);
      if (i == 0) check("R6 accept leaves busy only", r, 64'd1);
      if (!r[0]) break;
      busy++;
      @(negedge clk);
    end
  endtask

  task automatic run_cmd(input bit wide, input logic [11:0] a, input logic [63:0] v,
                         output logic [63:0] r, output int busy);
    wr(0, wide, a, v);
    wait_done(r, busy);
  endtask

  function automatic int lowest_free();
    for (int i = 1; i < PS; i++) if (!used[i]) return i;
    return 0;
  endfunction

  task automatic do_alloc(input string tag);
    logic [63:0] r; int b; int e;
    e = lowest_free();
    run_cmd(1, 12'hE10, 64'h1, r, b);
    if (e != 0) begin
      check({tag, " R4 grant"}, r, 64'(e) << 8);
      check({tag, " R5 busy cycles"}, 64'(b), 64'(e));
      used[e] = 1'b1;
    end else begin
      check({tag, " R10 pool empty"}, r, 64'd4);
    end
  endtask

  task automatic do_free(input string tag, input logic [19:0] id);
    logic [63:0] r; int b; bit ok;
    ok = (id != 0) && (id < PS) && used[id[3:0]];
    run_cmd(1, 12'hE10, {36'd0, id, 8'd2}, r, b);
    check({tag, " R5 busy one"}, 64'(b), 64'd1);
    if (ok) begin
      check({tag, " R11 release ok"}, r, 64'd0);
      used[id[3:0]] = 1'b0;
    end else begin
      check({tag, " R12 bad release"}, r, 64'd4);
    end
  endtask

  task automatic apply_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    used = '0;
  endtask

  task automatic t_reset();
    logic [63:0] d;
    rd(0, 1, 12'hE00, d); check("R1 cap", d, 64'd1);
    rd(0, 1, 12'hE10, d); check("R1 cmd", d, 64'd0);
    rd(0, 1, 12'hE20, d); check("R1 rsp", d, 64'd0);
    rd(1, 1, 12'hE00, d); check("R1 cap disabled", d, 64'd0);
    rd(0, 0, 12'hE04, d); check("R2 cap upper half", d, 64'd0);
    rd(0, 0, 12'hE00, d); check("R2 cap lower half", d, 64'd1);
  endtask

  task automatic t_readonly();
    logic [63:0] d;
    wr(0, 1, 12'hE00, '1);
    wr(0, 1, 12'hE20, 64'hFFFF_FFFF_FFFF_FFFE);
    rd(0, 1, 12'hE00, d); check("R3 cap unchanged", d, 64'd1);
    rd(0, 1, 12'hE20, d); check("R3 rsp unchanged", d, 64'd0);
  endtask

  task automatic t_busy_drop();
    logic [63:0] r, d; int b;
    wr(0, 1, 12'hE10, 64'h1);
    wr(0, 1, 12'hE10, 64'h0000_0000_0000_0102);
    rd(0, 1, 12'hE10, d); check("R7 cmd kept", d, 64'h1);
    for (int i = 0; i < 100; i++) begin
      rd(0, 1, 12'hE20, r);
      if (!r[0]) break;
      @(negedge clk);
    end
    check("R7 running alloc result", r, 64'd4 << 8);
    used[4] = 1'b1;
    b = 0;
    do_free("R7 id1 still held", 20'd1);
  endtask

  task automatic t_undef();
    logic [63:0] vals [4] = '{64'h0, 64'h3, 64'hFF, 64'h1234_5600};
    logic [63:0] r; int b;
    foreach (vals[i]) begin
      run_cmd(1, 12'hE10, vals[i], r, b);
      check("R9 undefined status", r, 64'd2);
      check("R9 busy one", 64'(b), 64'd1);
    end
  endtask

  task automatic t_release();
    do_free("R11 free 2", 20'd2);
    do_alloc("R11 regrant");
    do_free("R12 zero", 20'd0);
    do_free("R12 at limit", 20'(PS));
    do_free("R12 max id", 20'hFFFFF);
    do_free("R12 not held", 20'd9);
    do_alloc("R12 pool unchanged");
  endtask

  task automatic t_halves();
    logic [63:0] r, d; int b; int e;
    e = lowest_free();
    run_cmd(0, 12'hE10, 64'h1, r, b);
    check("R13 low half starts", r, 64'(e) << 8); used[e] = 1'b1;
    e = lowest_free();
    run_cmd(0, 12'hE14, 64'hABCD, r, b);
    check("R13 high half starts", r, 64'(e) << 8); used[e] = 1'b1;
    rd(0, 1, 12'hE10, d); check("R13 merged cmd", d, 64'h0000_ABCD_0000_0001);
    rd(0, 0, 12'hE14, d); check("R2 cmd upper half", d, 64'hABCD);
    rd(0, 0, 12'hE20, d); check("R2 rsp lower half", d, 64'(e) << 8);
    rd(0, 0, 12'hE24, d); check("R2 rsp upper half", d, 64'd0);
  endtask

  task automatic t_exhaust();
    logic [63:0] r; int b;
    while (lowest_free() != 0) do_alloc("R4 fill");
    run_cmd(1, 12'hE10, 64'h1, r, b);
    check("R10 none left", r, 64'd4);
    check("R10 full scan busy", 64'(b), 64'(PS - 1));
  endtask

  task automatic t_nocap();
    logic [63:0] d;
    wr(1, 1, 12'hE10, 64'h1);
    @(negedge clk);
    rd(1, 1, 12'hE10, d); check("R8 cmd not stored", d, 64'd0);
    rd(1, 1, 12'hE20, d); check("R8 no response", d, 64'd0);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #750000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    apply_reset();
    t_reset();
    t_readonly();
    do_alloc("R4 a1");
    do_alloc("R4 a2");
    do_alloc("R4 a3");
    t_busy_drop();
    t_undef();
    t_release();
    t_halves();
    t_exhaust();
    t_nocap();
    apply_reset();
    do_alloc("R14 after reset");
    check("R14 first grant is 1", 64'(used[1]), 64'd1);
    done = 1'b1;
    finish_run();
  end
endmodule